// File: doc/BRIEF.md
# Two-Level Context Address Translator

This block turns 32-bit virtual addresses into 28-bit physical addresses for a memory system with eight address contexts. A per-context segment table, selected by the current context and a slice of the virtual address, yields a page-group number. That number, joined with the page slice of the virtual address, selects one entry of a page table shared by all contexts. The page entry supplies the upper physical address bits and a byte of permission and type flags, which are passed through unchanged for downstream fault and cache logic to use.

A second, register-style access port lets system software manage the tables and two control registers. It is selected by an alternate-space code: one space holds the context register and a system enable byte, one reaches segment entries and one reaches page entries. Both table spaces locate their entry through the same walk that translation uses, so software addresses an entry by naming a virtual address in the current context.

The table depths are parameters. The full arrangement uses 12 segment-index bits (virtual bits 29:18) and a 7-bit page-group number (8192 page entries); the defaults are smaller (6 and 5) so that storage stays modest. Virtual address bits above the segment-index field are not used.

Top module: `mmu_xlate`

## Requirements
- R1: With rst_n low at a clock edge, xl_out_valid and acc_rvalid go low, the context register becomes 0 and the system enable byte becomes 0.
- R2: A translation request presented with xl_valid high at a clock edge produces xl_out_valid high and its result after that edge, one cycle later; with xl_valid low the following cycle shows xl_out_valid low.
- R3: The segment entry used is the one at the current context and virtual bits starting at bit 18 (SEG_IDX_W bits wide); each context owns a separate set of segment entries.
- R4: The page entry used is at index {low PMEG_W bits of the segment entry, virtual bits 17:12}.
- R5: xl_paddr equals {page entry bits 15:0, virtual bits 11:0}; xl_flags equals page entry bits 31:24, in order from bit 7: valid, writable, supervisor-only, non-cacheable, memory type (2 bits), accessed, modified.
- R6: In space 2 with acc_addr[31:28] equal to 3, a write loads the context register from acc_wdata[26:24], and a read returns the context in bits 26:24 with every other bit zero.
- R7: A context write takes effect for translations presented in the following cycle; a translation presented in the same cycle as the write uses the old context.
- R8: In space 2 with acc_addr[31:28] equal to 4, a write stores acc_wdata[7:0] into the system enable byte, and a read returns it in bits 31:24 with bits 23:0 zero.
- R9: A space 4 write updates the page entry selected through the walk of R3/R4 (using acc_addr and the current context) only in the byte lanes whose acc_mask bit is set (bit i covers bits 8i+7:8i), then forces entry bits 23:16 to zero; a space 4 read returns the whole entry.
- R10: A space 3 write shifts acc_wdata right so that the lowest enabled byte lane lands at bit 0 and stores the low 8 bits as the segment entry; a space 3 read returns the entry shifted left to the lowest enabled lane of acc_mask (lane 0 when the mask is zero).
- R11: Read data appears on acc_rdata with acc_rvalid high in the cycle after a read request; reads of any other space or space-2 offset return zero, and writes there change no register.

Ports

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_valid | input | 1 | Translation request |
| xl_vaddr | input | 32 | Virtual address to translate |
| xl_out_valid | output | 1 | Translation result valid |
| xl_paddr | output | 28 | Physical address |
| xl_flags | output | 8 | Page entry permission and type bits |
| acc_req | input | 1 | Register port access request |
| acc_we | input | 1 | Access is a write |
| acc_space | input | ASI_W | Alternate-space code |
| acc_addr | input | 32 | Access offset / virtual address |
| acc_mask | input | 4 | Byte-lane enables |
| acc_wdata | input | 32 | Write data |
| acc_rvalid | output | 1 | Read data valid |
| acc_rdata | output | 32 | Read data |

## Verification
Translations are tried in two contexts whose segment entries point at different page groups, so a wrong context or a wrong segment slice yields a recognisably different physical address. Page entries carry distinct high halves and flag bytes, which separates the page-number concatenation from the offset bits and catches lane mix-ups. A context write issued in the same cycle as a translation, followed by a second translation of the same address, distinguishes old-context from new-context use. Single-lane masks on segment and page accesses expose alignment and merge errors, and writes and reads to unused offsets show that nothing else is disturbed.

// File: rtl/mmu_pkg.sv
// Shared constants and helpers for the two-level translator.
// Assumes four byte lanes on the register port.
package mmu_pkg;
    localparam int LANES       = 4;
    localparam int PG_OFF_W    = 12;
    localparam int PG_SEL_W    = 6;
    localparam int SEG_LSB     = PG_OFF_W + PG_SEL_W;
    localparam int PFN_W       = 16;
    localparam int PA_W        = PFN_W + PG_OFF_W;
    localparam int FLAG_LSB    = 24;

    localparam int SPC_CTRL    = 2;
    localparam int SPC_SEG     = 3;
    localparam int SPC_PAGE    = 4;
    localparam int CTRL_CTX    = 3;
    localparam int CTRL_SYSEN  = 4;

    // Index of the lowest enabled byte lane, 0 when none is enabled.
    function automatic logic [1:0] low_lane(input logic [LANES-1:0] m);
        logic [1:0] r;
        r = 2'd0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i]) r = 2'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/mmu_segmap.sv
// Segment table: one entry per (context, segment index).
// Port A serves translation, port B the register port; reads are
// combinational, the single write is taken at the clock edge.
module mmu_segmap #(
    parameter int CTX_W     = 3,
    parameter int SEG_IDX_W = 6,
    parameter int ENT_W     = 8
) (
    input  logic                 clk,
    input  logic [CTX_W-1:0]     a_ctx,
    input  logic [SEG_IDX_W-1:0] a_idx,
    output logic [ENT_W-1:0]     a_ent,
    input  logic [CTX_W-1:0]     b_ctx,
    input  logic [SEG_IDX_W-1:0] b_idx,
    output logic [ENT_W-1:0]     b_ent,
    input  logic                 we,
    input  logic [ENT_W-1:0]     wdata
);
    localparam int DEPTH = 1 << (CTX_W + SEG_IDX_W);

    logic [ENT_W-1:0] mem [DEPTH];

    // Lookups for both ports.
    always_comb begin
        a_ent = mem[{a_ctx, a_idx}];
        b_ent = mem[{b_ctx, b_idx}];
    end

    // Store one entry from the register port.
    always_ff @(posedge clk) begin
        if (we) mem[{b_ctx, b_idx}] <= wdata;
    end
endmodule

// File: rtl/mmu_pagemap.sv
// Shared page table. Port A serves translation, port B the register
// port. A write merges enabled byte lanes into the old entry and then
// clears bits 23:16.
module mmu_pagemap #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] a_idx,
    output logic [31:0]      a_ent,
    input  logic [IDX_W-1:0] b_idx,
    output logic [31:0]      b_ent,
    input  logic             we,
    input  logic [3:0]       wmask,
    input  logic [31:0]      wdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [31:0] mem [DEPTH];
    logic [31:0] bitmask;
    logic [31:0] merged;

    // Expand byte enables into a bit mask.
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign bitmask[8*g +: 8] = {8{wmask[g]}};
    end

    // Lookups for both ports.
    always_comb begin
        a_ent = mem[a_idx];
        b_ent = mem[b_idx];
    end

    // Merge new lanes with the old entry and clear the reserved byte.
    always_comb begin
        merged        = (b_ent & ~bitmask) | (wdata & bitmask);
        merged[23:16] = 8'h00;
    end

    // Store the merged entry.
    always_ff @(posedge clk) begin
        if (we) mem[b_idx] <= merged;
    end
endmodule

// File: rtl/mmu_xlate.sv
// Two-level context address translator with an alternate-space
// register port. Translation is registered (one cycle). Register port
// reads are registered (one cycle). Assumes SEG_ENT_W >= PMEG_W.
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int ASI_W     = 8,
    parameter int CTX_W     = 3,
    parameter int SEG_IDX_W = 6,
    parameter int PMEG_W    = 5,
    parameter int SEG_ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xl_valid,
    input  logic [31:0]      xl_vaddr,
    output logic             xl_out_valid,
    output logic [27:0]      xl_paddr,
    output logic [7:0]       xl_flags,
    input  logic             acc_req,
    input  logic             acc_we,
    input  logic [ASI_W-1:0] acc_space,
    input  logic [31:0]      acc_addr,
    input  logic [3:0]       acc_mask,
    input  logic [31:0]      acc_wdata,
    output logic             acc_rvalid,
    output logic [31:0]      acc_rdata
);
    localparam int PG_IDX_W = PMEG_W + PG_SEL_W;

    logic [CTX_W-1:0]     ctx_q;
    logic [7:0]           sysen_q;
    logic [SEG_ENT_W-1:0] seg_a, seg_b, seg_wdata;
    logic [PG_IDX_W-1:0]  pg_a_idx, pg_b_idx;
    logic [31:0]          pte_a, pte_b;
    logic                 sel_ctrl, sel_seg, sel_page;
    logic                 wr_ctx, wr_sysen, wr_seg, wr_page;
    logic [4:0]           lane_sh;
    logic [31:0]          seg_wshift, rd_next;

    // Decode which space the access targets.
    always_comb begin
        sel_ctrl = acc_space == ASI_W'(SPC_CTRL);
        sel_seg  = acc_space == ASI_W'(SPC_SEG);
        sel_page = acc_space == ASI_W'(SPC_PAGE);
        wr_ctx   = acc_req && acc_we && sel_ctrl && acc_addr[31:28] == 4'(CTRL_CTX);
        wr_sysen = acc_req && acc_we && sel_ctrl && acc_addr[31:28] == 4'(CTRL_SYSEN);
        wr_seg   = acc_req && acc_we && sel_seg;
        wr_page  = acc_req && acc_we && sel_page;
        lane_sh  = {low_lane(acc_mask), 3'b000};
    end

    // Right-align segment write data to the lowest enabled lane.
    always_comb begin
        seg_wshift = acc_wdata >> lane_sh;
        seg_wdata  = seg_wshift[SEG_ENT_W-1:0];
    end

    // Page indices: page-group number from the segment entry plus page select.
    always_comb begin
        pg_a_idx = {seg_a[PMEG_W-1:0], xl_vaddr[PG_OFF_W +: PG_SEL_W]};
        pg_b_idx = {seg_b[PMEG_W-1:0], acc_addr[PG_OFF_W +: PG_SEL_W]};
    end

    mmu_segmap #(
        .CTX_W(CTX_W), .SEG_IDX_W(SEG_IDX_W), .ENT_W(SEG_ENT_W)
    ) u_seg (
        .clk   (clk),
        .a_ctx (ctx_q),
        .a_idx (xl_vaddr[SEG_LSB +: SEG_IDX_W]),
        .a_ent (seg_a),
        .b_ctx (ctx_q),
        .b_idx (acc_addr[SEG_LSB +: SEG_IDX_W]),
        .b_ent (seg_b),
        .we    (wr_seg),
        .wdata (seg_wdata)
    );

    mmu_pagemap #(
        .IDX_W(PG_IDX_W)
    ) u_page (
        .clk   (clk),
        .a_idx (pg_a_idx),
        .a_ent (pte_a),
        .b_idx (pg_b_idx),
        .b_ent (pte_b),
        .we    (wr_page),
        .wmask (acc_mask),
        .wdata (acc_wdata)
    );

    // Select read data for the addressed space.
    always_comb begin
        rd_next = '0;
        if (sel_ctrl) begin
            if (acc_addr[31:28] == 4'(CTRL_CTX))
                rd_next[FLAG_LSB +: CTX_W] = ctx_q;
            else if (acc_addr[31:28] == 4'(CTRL_SYSEN))
                rd_next[31:24] = sysen_q;
        end else if (sel_seg) begin
            rd_next = {{(32-SEG_ENT_W){1'b0}}, seg_b} << lane_sh;
        end else if (sel_page) begin
            rd_next = pte_b;
        end
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            sysen_q <= '0;
        end else begin
            if (wr_ctx)   ctx_q   <= acc_wdata[FLAG_LSB +: CTX_W];
            if (wr_sysen) sysen_q <= acc_wdata[7:0];
        end
    end

    // Register port read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_rvalid <= 1'b0;
            acc_rdata  <= '0;
        end else begin
            acc_rvalid <= acc_req && !acc_we;
            if (acc_req && !acc_we) acc_rdata <= rd_next;
        end
    end

    // Translation result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_out_valid <= 1'b0;
            xl_paddr     <= '0;
            xl_flags     <= '0;
        end else begin
            xl_out_valid <= xl_valid;
            if (xl_valid) begin
                xl_paddr <= {pte_a[PFN_W-1:0], xl_vaddr[PG_OFF_W-1:0]};
                xl_flags <= pte_a[31:FLAG_LSB];
            end
        end
    end
endmodule

// File: rtl/mmu_xlate_chk.sv
// Protocol checks for mmu_xlate, bound to every instance.
module mmu_xlate_chk #(
    parameter int ASI_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xl_valid,
    input logic [31:0]      xl_vaddr,
    input logic             xl_out_valid,
    input logic [27:0]      xl_paddr,
    input logic             acc_req,
    input logic             acc_we,
    input logic [ASI_W-1:0] acc_space,
    input logic [31:0]      acc_addr,
    input logic             acc_rvalid,
    input logic [31:0]      acc_rdata
);
    logic rd_req, rd_ctx, rd_sysen, rd_page;
    assign rd_req   = acc_req && !acc_we;
    assign rd_ctx   = rd_req && acc_space == ASI_W'(2) && acc_addr[31:28] == 4'd3;
    assign rd_sysen = rd_req && acc_space == ASI_W'(2) && acc_addr[31:28] == 4'd4;
    assign rd_page  = rd_req && acc_space == ASI_W'(4);

    // R2
    xl_valid_then_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> xl_out_valid);
    // R2
    xl_idle_then_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_valid |=> !xl_out_valid);
    // R5
    xl_offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |=> xl_paddr[11:0] == $past(xl_vaddr[11:0]));
    // R11
    rd_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> acc_rvalid);
    // R11
    no_rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !acc_rvalid);
    // R6
    ctx_read_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctx |=> (acc_rdata[31:27] == 5'd0 && acc_rdata[23:0] == 24'd0));
    // R8
    sysen_read_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sysen |=> acc_rdata[23:0] == 24'd0);
    // R9
    page_read_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_page |=> acc_rdata[23:16] == 8'd0);
endmodule

bind mmu_xlate mmu_xlate_chk #(.ASI_W(ASI_W)) u_chk (.*);

// File: tb/mmu_xlate_tb_top.sv
`timescale 1ns/1ps
module mmu_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_valid = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic        xl_out_valid;
    logic [27:0] xl_paddr;
    logic [7:0]  xl_flags;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_space = '0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_mask = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_rvalid;
    logic [31:0] acc_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [35:0] xl_q[$];
    string       xl_tag[$];
    logic [31:0] rd_q[$];
    string       rd_tag[$];

    always #4 clk = ~clk;

    mmu_xlate dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        xl_valid = 1'b0; xl_vaddr = '0;
        acc_req = 1'b0; acc_we = 1'b0; acc_space = '0;
        acc_addr = '0; acc_mask = '0; acc_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); clear_in();
        end
    endtask

    task automatic wr(input logic [7:0] sp, input logic [31:0] a, input logic [3:0] m, input logic [31:0] d);
        @(negedge clk); clear_in();
        acc_req = 1'b1; acc_we = 1'b1; acc_space = sp; acc_addr = a; acc_mask = m; acc_wdata = d;
    endtask

    task automatic rd(input logic [7:0] sp, input logic [31:0] a, input logic [3:0] m,
                      input logic [31:0] exp, input string req);
        @(negedge clk); clear_in();
        acc_req = 1'b1; acc_space = sp; acc_addr = a; acc_mask = m;
        rd_q.push_back(exp); rd_tag.push_back(req);
    endtask

    task automatic xl(input logic [31:0] va, input logic [27:0] pa, input logic [7:0] fl, input string req);
        @(negedge clk); clear_in();
        xl_valid = 1'b1; xl_vaddr = va;
        xl_q.push_back({pa, fl}); xl_tag.push_back(req);
    endtask

    // Monitor: pop expected results as the design produces them.
    always @(negedge clk) begin
        if (rst_n) begin
            if (xl_out_valid) begin
                if (xl_q.size() == 0) check(1'b0, "R2 unexpected result", {xl_paddr, xl_flags}, '0);
                else begin
                    logic [35:0] e; string t;
                    e = xl_q.pop_front(); t = xl_tag.pop_front();
                    check({xl_paddr, xl_flags} === e, t, {xl_paddr, xl_flags}, e);
                end
            end
            if (acc_rvalid) begin
                if (rd_q.size() == 0) check(1'b0, "R11 unexpected read", {4'd0, acc_rdata}, '0);
                else begin
                    logic [31:0] e; string t;
                    e = rd_q.pop_front(); t = rd_tag.pop_front();
                    check(acc_rdata === e, t, {4'd0, acc_rdata}, {4'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low while and right after reset
        check(xl_out_valid === 1'b0 && acc_rvalid === 1'b0, "R1 valids low in reset",
              {34'd0, xl_out_valid, acc_rvalid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(xl_out_valid === 1'b0 && acc_rvalid === 1'b0, "R1 valids low after reset",
              {34'd0, xl_out_valid, acc_rvalid}, '0);
        rd(8'd2, 32'h3000_0000, 4'hF, 32'h0000_0000, "R1 context reset");
        rd(8'd2, 32'h4000_0000, 4'hF, 32'h0000_0000, "R1 enable reset");

        // R8: enable byte
        wr(8'd2, 32'h4000_0000, 4'hF, 32'h0000_00A5);
        rd(8'd2, 32'h4000_0000, 4'hF, 32'hA500_0000, "R8 enable byte");
        wr(8'd2, 32'h4000_0000, 4'hF, 32'hFFFF_FF3C);
        rd(8'd2, 32'h4000_0000, 4'hF, 32'h3C00_0000, "R8 enable low byte only");

        // R6: context register
        wr(8'd2, 32'h3000_0000, 4'hF, 32'h05FF_FFFF);
        rd(8'd2, 32'h3000_0000, 4'hF, 32'h0500_0000, "R6 context field");

        // R11: unused offset and space
        wr(8'd2, 32'h5000_0000, 4'hF, 32'h0700_0000);
        rd(8'd2, 32'h3000_0000, 4'hF, 32'h0500_0000, "R11 unused write keeps context");
        rd(8'd2, 32'h4000_0000, 4'hF, 32'h3C00_0000, "R11 unused write keeps enable");
        rd(8'd2, 32'h5000_0000, 4'hF, 32'h0000_0000, "R11 unused offset reads zero");
        rd(8'd7, 32'h0000_0000, 4'hF, 32'h0000_0000, "R11 unused space reads zero");

        // R10: segment entries in context 5
        wr(8'd3, 32'h0008_0000, 4'b0010, 32'h0000_0A00);
        rd(8'd3, 32'h0008_0000, 4'b0100, 32'h000A_0000, "R10 segment left-align lane 2");
        rd(8'd3, 32'h0008_0000, 4'b0001, 32'h0000_000A, "R10 segment lane 0");
        wr(8'd3, 32'h000C_0000, 4'b1000, 32'h1300_0000);
        rd(8'd3, 32'h000C_0000, 4'b1000, 32'h1300_0000, "R10 segment lane 3");

        // R9: page entries
        wr(8'd4, 32'h0008_1000, 4'hF, 32'hFFFF_1234);
        rd(8'd4, 32'h0008_1000, 4'hF, 32'hFF00_1234, "R9 page bits 23:16 cleared");
        wr(8'd4, 32'h0008_2000, 4'hF, 32'h8C5A_ABCD);
        wr(8'd4, 32'h0008_2000, 4'b0001, 32'hFFFF_FF77);
        rd(8'd4, 32'h0008_2000, 4'hF, 32'h8C00_AB77, "R9 page lane merge");
        wr(8'd4, 32'h000C_3000, 4'hF, 32'hA000_0FED);
        rd(8'd4, 32'h000C_3000, 4'hF, 32'hA000_0FED, "R9 page full write");

        // R2 R3 R4 R5: back-to-back translations in context 5
        xl(32'h0008_1ABC, 28'h1234_ABC, 8'hFF, "R5 translate page 1");
        xl(32'h0008_2123, 28'hAB77_123, 8'h8C, "R4 translate page 2");
        xl(32'h000C_3456, 28'h0FED_456, 8'hA0, "R3 translate segment 3");
        xl(32'h8008_1001, 28'h1234_001, 8'hFF, "R3 high bits unused");
        idle(2);

        // R3: context 2 has its own segment entries
        wr(8'd2, 32'h3000_0000, 4'hF, 32'h0200_0000);
        wr(8'd3, 32'h0008_0000, 4'b0001, 32'h0000_0007);
        wr(8'd4, 32'h0008_1000, 4'hF, 32'h4000_5555);
        rd(8'd3, 32'h0008_0000, 4'b0001, 32'h0000_0007, "R3 context 2 segment");
        xl(32'h0008_1000, 28'h5555_000, 8'h40, "R3 translate in context 2");

        // R7: context write and translation in the same cycle
        @(negedge clk); clear_in();
        acc_req = 1'b1; acc_we = 1'b1; acc_space = 8'd2; acc_addr = 32'h3000_0000;
        acc_mask = 4'hF; acc_wdata = 32'h0500_0000;
        xl_valid = 1'b1; xl_vaddr = 32'h0008_1000;
        xl_q.push_back({28'h5555_000, 8'h40}); xl_tag.push_back("R7 same cycle uses old context");
        xl(32'h0008_1000, 28'h1234_000, 8'hFF, "R7 next cycle uses new context");
        idle(4);

        check(xl_q.size() == 0 && rd_q.size() == 0, "R2 all results seen",
              36'(xl_q.size() + rd_q.size()), '0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule